// File: doc/BRIEF.md
# Bitslip Capable Input Deserializer

This block turns a group of serial lanes, each carrying one bit per bit time, into parallel words for the slower fabric clock. A fast bit clock samples every lane. A divided word clock, whose rising edges fall on bit-clock rising edges, collects one word per lane per word period. A parameter selects single data rate (one bit per bit-clock cycle, on the rising edge) or double data rate (two bits per cycle, on the falling edge and then on the next rising edge). For ratios above eight bits, each lane's collector is built as two chained stages of at most eight bits.

Each lane has its own bitslip request. Every accepted request moves that lane's word boundary by one bit, so the receiver can align to the framing of the incoming stream without touching the other lanes. The output bus packs bits by timeslice: all lanes' earliest bit first, then all lanes' next bit, and so on. This makes the word for timeslice t a contiguous group of LANES bits.

Top module: `bitslip_deser`

## Requirements
- R1: The ratio is legal only in one of two sets. With DDR = 0 the legal ratios are 2 to 8. With DDR = 1 the legal ratios are 4, 6, 8, 10 and 14. An illegal pair stops elaboration.
- R2: While rst_n is low, par_out is zero, and it goes to zero without waiting for a clock edge. A reset also returns every lane's bitslip offset to zero.
- R3: Within a lane, an earlier bit lands at a lower timeslice. With DDR = 1, the bit sampled on a falling edge of clk_bit precedes the bit sampled on the following rising edge.
- R4: Bit par_out[t*LANES + l] holds lane l at timeslice t, with t running from 0 (earliest) to RATIO-1.
- R5: A word period is the RATIO bits sampled at the bit-clock rising edges from one word-clock rising edge up to the edge before the next one, plus (with DDR = 1) the falling edges just before each of those rising edges. With a zero offset, that period's bits appear on par_out one word-clock edge after the period closes.
- R6: A lane with offset s presents, at timeslice t, the bit that lies s bit times earlier in the stream than with offset 0. Older bits come from the previous word.
- R7: A bitslip request is sampled at a word-clock rising edge. par_out uses the new offset from the next word-clock edge onward, that is within two word-clock edges.
- R8: A bitslip request held high over several word-clock edges counts once. Only a low-to-high change of slip_req[l] at a word-clock edge advances the offset.
- R9: A request on one lane changes no other lane's bits, and a lane whose request stays low keeps its framing.
- R10: The offset counts modulo RATIO. After RATIO accepted requests, a lane returns to its original framing.
- R11: For a ratio above 8, each lane's collector is two chained stages of at most 8 bits each, with the same behaviour at the ports as a single stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Fast bit clock sampling the serial lanes |
| clk_word | input | 1 | Divided word clock, period RATIO/(DDR+1) bit-clock cycles, rising edges on bit-clock rising edges |
| rst_n | input | 1 | Asynchronous active-low reset, released per clock domain through synchronizers |
| slip_req | input | LANES | Per-lane bitslip request, sampled on clk_word |
| ser_in | input | LANES | Serial data, one bit per lane |
| par_out | output | LANES*RATIO | Parallel words packed by timeslice |

## Verification
The bench keeps its own copy of the serial stream from the values it drives. At each word-clock edge it forms the word due one edge later, from the two most recent word periods and its own count of each lane's offset. It then compares par_out half a bit period after that edge, when the output register has settled. Directed checks on a timeslice-coded pattern sample par_out five nanoseconds after the edge that follows the one where a request was sampled; this is where R7 places the new framing. The asynchronous reset is checked one nanosecond after rst_n falls, before any clock edge.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  // Widest collector stage; larger ratios are split into two chained stages.
  localparam int STAGE_MAX = 8;

  // Legal deserialization ratios per data-rate mode.
  function automatic bit ratio_ok(input int ratio, input int ddr);
    if (ddr != 0)
      return (ratio == 4) || (ratio == 6) || (ratio == 8) ||
             (ratio == 10) || (ratio == 14);
    return (ratio >= 2) && (ratio <= STAGE_MAX);
  endfunction
endpackage

// File: rtl/bsd_rst_sync.sv
module bsd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic meta_d;

  assign meta_d = 1'b1;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= meta_d;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/bsd_lane_capture.sv
module bsd_lane_capture #(
  parameter int RATIO = 10,
  parameter int DDR   = 1
) (
  input  logic             clk_bit,
  input  logic             rst_n,
  input  logic             ser_in,
  output logic [RATIO-1:0] frame
);
  localparam int BPC     = (DDR != 0) ? 2 : 1;
  localparam bit CASCADE = RATIO > bsd_pkg::STAGE_MAX;

  logic [BPC-1:0] new_bits;

  // Bit order: earlier sample at lower index (falling-edge bit before rising-edge bit).
  generate
    if (DDR != 0) begin : g_ddr
      logic fall_q;
      always_ff @(negedge clk_bit or negedge rst_n) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= ser_in;
      end
      assign new_bits = {ser_in, fall_q};
    end else begin : g_sdr
      assign new_bits = ser_in;
    end
  endgenerate

  generate
    if (CASCADE) begin : g_cascade
      // R11: two chained stages, the newer one at most STAGE_MAX wide.
      localparam int HI_W = bsd_pkg::STAGE_MAX;
      localparam int LO_W = RATIO - HI_W;
      logic [HI_W-1:0] hi_q, hi_d;
      logic [LO_W-1:0] lo_q, lo_d;

      always_comb begin
        hi_d = HI_W'({new_bits, hi_q} >> BPC);
        lo_d = LO_W'({hi_q[BPC-1:0], lo_q} >> BPC);
      end

      always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) begin
          hi_q <= '0;
          lo_q <= '0;
        end else begin
          hi_q <= hi_d;
          lo_q <= lo_d;
        end
      end

      assign frame = {hi_q, lo_q};

      assert_cascade_handoff_R11: assert property (@(posedge clk_bit) disable iff (!rst_n)
        $past(rst_n) |-> (lo_q[LO_W-1 -: BPC] == $past(hi_q[BPC-1:0])));
    end else begin : g_single
      logic [RATIO-1:0] sr_q, sr_d;

      always_comb sr_d = RATIO'({new_bits, sr_q} >> BPC);

      always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
      end

      assign frame = sr_q;
    end
  endgenerate
endmodule

// File: rtl/bsd_lane_framer.sv
module bsd_lane_framer #(
  parameter int RATIO = 10
) (
  input  logic             clk_word,
  input  logic             rst_n,
  input  logic [RATIO-1:0] frame_in,
  input  logic             slip_in,
  output logic [RATIO-1:0] word_out
);
  localparam int SW = $clog2(RATIO);
  localparam logic [SW-1:0] SLIP_MAX = SW'(RATIO - 1);
  localparam logic [SW:0]   RATIO_V  = (SW + 1)'(RATIO);

  logic [RATIO-1:0] cur_q, prev_q, word_q, word_d;
  logic [SW-1:0]    slip_q, slip_d;
  logic             bs_q;
  logic             slip_pulse;
  logic [SW:0]      shamt;

  // Next-state logic.
  always_comb begin
    slip_pulse = slip_in & ~bs_q;
    slip_d     = slip_q;
    if (slip_pulse) begin
      if (slip_q == SLIP_MAX) slip_d = '0;
      else                    slip_d = slip_q + 1'b1;
    end
    shamt  = RATIO_V - {1'b0, slip_q};
    word_d = RATIO'({cur_q, prev_q} >> shamt);
  end

  // Register process.
  always_ff @(posedge clk_word or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
      word_q <= '0;
      slip_q <= '0;
      bs_q   <= 1'b0;
    end else begin
      cur_q  <= frame_in;
      prev_q <= cur_q;
      word_q <= word_d;
      bs_q   <= slip_in;
      if (slip_pulse) slip_q <= slip_d;
    end
  end

  assign word_out = word_q;

  assert_slip_step_R6: assert property (@(posedge clk_word) disable iff (!rst_n)
    (slip_in && !bs_q && $past(slip_q) != SLIP_MAX) |=> (slip_q != $past(slip_q)));

  assert_slip_wrap_R10: assert property (@(posedge clk_word) disable iff (!rst_n)
    (slip_in && !bs_q && slip_q == SLIP_MAX) |=> (slip_q == '0));

  assert_held_once_R8: assert property (@(posedge clk_word) disable iff (!rst_n)
    (slip_in && bs_q) |=> $stable(slip_q));

  assert_idle_keeps_R9: assert property (@(posedge clk_word) disable iff (!rst_n)
    (!slip_in) |=> $stable(slip_q));

  assert_slip_range_R10: assert property (@(posedge clk_word) disable iff (!rst_n)
    slip_q <= SLIP_MAX);
endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser #(
  parameter int LANES = 4,
  parameter int RATIO = 10,
  parameter int DDR   = 1
) (
  input  logic                   clk_bit,
  input  logic                   clk_word,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       slip_req,
  input  logic [LANES-1:0]       ser_in,
  output logic [LANES*RATIO-1:0] par_out
);
  localparam int OUT_W = LANES * RATIO;

  // R1: only the legal ratio sets elaborate.
  generate
    if (!bsd_pkg::ratio_ok(RATIO, DDR)) begin : g_bad_ratio
      $error("bitslip_deser: ratio not legal for the chosen data rate");
    end
  endgenerate

  logic bit_rst_n;
  logic word_rst_n;
  logic [RATIO-1:0] lane_frame [LANES];
  logic [RATIO-1:0] lane_word  [LANES];

  bsd_rst_sync u_bit_rst (
    .clk    (clk_bit),
    .arst_n (rst_n),
    .srst_n (bit_rst_n)
  );

  bsd_rst_sync u_word_rst (
    .clk    (clk_word),
    .arst_n (rst_n),
    .srst_n (word_rst_n)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      bsd_lane_capture #(.RATIO(RATIO), .DDR(DDR)) u_cap (
        .clk_bit (clk_bit),
        .rst_n   (bit_rst_n),
        .ser_in  (ser_in[l]),
        .frame   (lane_frame[l])
      );

      bsd_lane_framer #(.RATIO(RATIO)) u_frm (
        .clk_word (clk_word),
        .rst_n    (word_rst_n),
        .frame_in (lane_frame[l]),
        .slip_in  (slip_req[l]),
        .word_out (lane_word[l])
      );

      // R4: timeslice-major packing.
      for (genvar t = 0; t < RATIO; t++) begin : g_slice
        assign par_out[t*LANES + l] = lane_word[l][t];
      end
    end
  endgenerate

  assert_reset_zero_R2: assert property (@(posedge clk_word)
    (!rst_n) |-> (par_out == OUT_W'(0)));
endmodule

// File: tb/test_bitslip_deser.sv
module test_bitslip_deser;
  localparam int LANES = 4;
  localparam int RATIO = 10;
  localparam int DDR   = 1;
  localparam int BPC   = (DDR != 0) ? 2 : 1;
  localparam int CPW   = RATIO / BPC;
  localparam int W     = LANES * RATIO;

  logic             clk_bit, clk_word, rst_n;
  logic [LANES-1:0] slip_req, ser_in;
  logic [W-1:0]     par_out;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R5";
  bit    word_edge;
  int    cyc;
  int    mode;       // 0 zeros, 1 random, 2 timeslice pattern
  bit    check_on;
  bit    done;

  // Bench model state.
  logic [LANES-1:0] m_fall;
  logic [RATIO-1:0] m_sr   [LANES];
  logic [RATIO-1:0] m_cur  [LANES];
  logic [RATIO-1:0] m_prev [LANES];
  int               m_slip [LANES];
  logic [LANES-1:0] m_bsq;
  logic [W-1:0]     m_exp;
  bit               pend;
  int               exp_slip [LANES];

  bitslip_deser #(.LANES(LANES), .RATIO(RATIO), .DDR(DDR)) i_bitslip_deser (
    .clk_bit  (clk_bit),
    .clk_word (clk_word),
    .rst_n    (rst_n),
    .slip_req (slip_req),
    .ser_in   (ser_in),
    .par_out  (par_out)
  );

  // 50 MHz bit clock; word clock edges on every CPW-th bit rising edge.
  initial begin
    clk_bit = 0; clk_word = 0; cyc = 0; word_edge = 0;
    forever begin
      #10;
      word_edge = (cyc == 0);
      if (cyc == 0) clk_word = 1;
      else if (cyc == CPW / 2) clk_word = 0;
      clk_bit = 1;
      #10;
      clk_bit = 0;
      cyc = (cyc + 1) % CPW;
    end
  end

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat_word();
    logic [W-1:0] w;
    w = '0;
    for (int l = 0; l < LANES; l++)
      for (int t = 0; t < RATIO; t++) begin
        int ts;
        ts = (t - exp_slip[l] + RATIO) % RATIO;
        w[t*LANES + l] = 1'((ts >> l) & 1);
      end
    return w;
  endfunction

  function automatic logic [LANES-1:0] gen_bits(input int ts);
    logic [LANES-1:0] b;
    if (mode == 1) b = LANES'($urandom);
    else if (mode == 2) b = LANES'(ts);
    else b = '0;
    return b;
  endfunction

  // Serial driver: first value sampled on the falling edge (DDR), second on the rising edge.
  initial begin
    ser_in = '0;
    forever begin
      int slot;
      @(posedge clk_bit);
      #5;
      slot = (cyc + 1) % CPW;
      ser_in = gen_bits(slot * BPC);
      if (DDR != 0) begin
        #10;
        ser_in = gen_bits(slot * BPC + 1);
      end
    end
  end

  // Model, from the requirements: window, packing, offsets.
  always @(posedge clk_bit) begin
    if (!rst_n) begin
      for (int l = 0; l < LANES; l++) begin
        m_sr[l] = '0; m_cur[l] = '0; m_prev[l] = '0; m_slip[l] = 0;
      end
      m_bsq = '0; m_exp = '0; pend = 0;
    end else begin
      if (word_edge) begin
        for (int l = 0; l < LANES; l++) begin
          logic [2*RATIO-1:0] pair;
          pair = {m_cur[l], m_prev[l]};
          for (int t = 0; t < RATIO; t++)
            m_exp[t*LANES + l] = pair[t + RATIO - m_slip[l]];
          m_prev[l] = m_cur[l];
          m_cur[l]  = m_sr[l];
          if (slip_req[l] && !m_bsq[l]) m_slip[l] = (m_slip[l] + 1) % RATIO;
        end
        m_bsq = slip_req;
        pend  = 1;
      end
      for (int l = 0; l < LANES; l++) begin
        if (DDR != 0) begin
          m_sr[l] = m_sr[l] >> 1;
          m_sr[l][RATIO-1] = m_fall[l];
        end
        m_sr[l] = m_sr[l] >> 1;
        m_sr[l][RATIO-1] = ser_in[l];
      end
    end
  end

  always @(negedge clk_bit) begin
    if (pend && check_on) chk(par_out, m_exp, cur_req);
    pend = 0;
    m_fall = ser_in;
  end

  task automatic words(input int n);
    repeat (n) @(posedge clk_word);
  endtask

  task automatic directed(input string req);
    @(posedge clk_word);
    #5;
    chk(par_out, pat_word(), req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd4711);
    done = 0; check_on = 0; mode = 0; rst_n = 0; slip_req = '0;
    for (int l = 0; l < LANES; l++) exp_slip[l] = 0;

    // R2: reset state.
    repeat (4) begin
      repeat (5) @(negedge clk_bit);
      chk(par_out, '0, "R2");
    end
    @(posedge clk_bit); #5; rst_n = 1;
    words(6);
    check_on = 1;

    // R1: legal ratio sets.
    for (int d = 0; d < 2; d++)
      for (int r = 1; r <= 16; r++) begin
        bit want;
        want = (d == 0) ? (r >= 2 && r <= 8)
                        : (r == 4 || r == 6 || r == 8 || r == 10 || r == 14);
        chk(W'(bsd_pkg::ratio_ok(r, d)), W'(want), "R1");
      end

    // R3 and R4: timeslice-coded pattern, zero offsets.
    cur_req = "R4";
    mode = 2;
    words(4);
    directed("R3");
    directed("R4");

    // R5 and R11: random data, framing and latency on the cascaded collector.
    mode = 1; cur_req = "R5";
    words(30);
    cur_req = "R11";
    words(10);

    // R6, R7, R9: single pulse on lane 1.
    mode = 2; cur_req = "R6";
    words(3);
    @(posedge clk_word); #5; slip_req[1] = 1;
    @(posedge clk_word); #5; slip_req[1] = 0;
    chk(par_out, pat_word(), "R7");   // sampled edge: old framing still shown
    exp_slip[1] = 1;
    @(posedge clk_word); #5;
    chk(par_out, pat_word(), "R7");
    directed("R6");
    directed("R9");

    // R8: held request counts once.
    cur_req = "R8";
    @(posedge clk_word); #5; slip_req[2] = 1;
    words(4);
    #5; slip_req[2] = 0;
    exp_slip[2] = 1;
    words(2);
    directed("R8");

    // R10: RATIO pulses restore framing.
    cur_req = "R10";
    for (int k = 0; k < RATIO; k++) begin
      @(posedge clk_word); #5; slip_req[3] = 1;
      @(posedge clk_word); #5; slip_req[3] = 0;
    end
    words(2);
    directed("R10");

    // R9: random requests and data on all lanes.
    mode = 1; cur_req = "R9";
    for (int k = 0; k < 300; k++) begin
      @(posedge clk_word); #5;
      slip_req = LANES'($urandom) & LANES'($urandom);
    end
    @(posedge clk_word); #5; slip_req = '0;
    words(3);

    // R2: asynchronous reset mid-run, offsets cleared.
    cur_req = "R2";
    check_on = 0;
    mode = 0;
    @(posedge clk_bit); #3; rst_n = 0;
    #1;
    chk(par_out, '0, "R2");
    repeat (10) @(posedge clk_bit);
    #2;
    chk(par_out, '0, "R2");
    @(posedge clk_bit); #5; rst_n = 1;
    words(6);
    check_on = 1;
    for (int l = 0; l < LANES; l++) exp_slip[l] = 0;
    mode = 2;
    words(4);
    directed("R2");
    words(2);

    finish_run();
  end
endmodule